// File: doc/BRIEF.md
# Control-Register Handshake Master

This block turns one host register request at a time into a sequence of four-phase strobe/acknowledge handshakes on a narrow control bus of a serial PHY. The host raises `host_req` for one cycle with the direction, the 16-bit register address and, for a write, the 16-bit write data. The block then works through the bus handshakes on its own and ends the request with a one-cycle `host_done` pulse. The pulse carries `host_err` if a handshake stalled. On a successful read, `host_rdata` carries the register value.

Each request opens with an address handshake. A write then needs a data handshake and then a commit handshake. A read needs one read handshake, during which the PHY returns the value. For every handshake the block first drives the lane value with all strobes low for a settle period. It then raises exactly one strobe and keeps it high until the acknowledge rises. It drops the strobe and waits for the acknowledge to fall before the next handshake starts. A watchdog bounds every wait on the acknowledge. If it expires, the request is abandoned.

Top module: `creg_bus_master`

## Requirements
- R1: After reset all four strobes are low, `bus_dat_o` is zero, `host_done` and `host_err` are low, and a request is accepted at once.
- R2: Every request starts with an address handshake. `bus_dat_o` carries the zero-extended address and `bus_cap_addr_o` is raised. A strobe only falls after the acknowledge was seen high in the previous cycle, or in the cycle of an aborting `host_done`/`host_err`.
- R3: A write (`host_we`=1) follows the address handshake with a data-capture handshake on `bus_cap_data_o` and then a commit handshake on `bus_wr_o`. The write data stays on `bus_dat_o` during both, and the request ends with `host_done`=1 and `host_err`=0.
- R4: A read (`host_we`=0) follows the address handshake with a handshake on `bus_rd_o` while `bus_dat_o` is zero. The value on `bus_dat_i` while the acknowledge is high appears on `host_rdata` together with the `host_done` pulse.
- R5: Before any strobe rises, `bus_dat_o` has held its value with all strobes low for at least SETUP_CYC cycles. It stays unchanged while a strobe is high.
- R6: At most one of the four strobes is high in any cycle.
- R7: A strobe that sees no acknowledge for TIMEOUT_CYC consecutive cycles, or an acknowledge that stays high for TIMEOUT_CYC cycles after the strobe fell, aborts the request. All strobes go low, `host_done` and `host_err` pulse together, `host_rdata` keeps its previous value, and no later handshake of that request takes place. An acknowledge arriving after TIMEOUT_CYC-1 waiting cycles still completes normally.
- R8: `host_req` is ignored while a request is in progress. No extra `host_done` pulse appears and no register is written because of it.
- R9: `host_done` is high for exactly one cycle per accepted request, and `host_err` is never high without `host_done`.
- R10: The whole 16-bit address space is reachable, including 0x0000 and 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Request strobe, sampled only while idle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Register address |
| host_wdata | input | DATA_W | Write data |
| host_done | output | 1 | One-cycle completion pulse |
| host_rdata | output | DATA_W | Read result, updated on a successful read |
| host_err | output | 1 | Abort flag, valid with host_done |
| bus_dat_o | output | LANE_W | Lane value presented to the PHY |
| bus_cap_addr_o | output | 1 | Address-capture strobe |
| bus_cap_data_o | output | 1 | Data-capture strobe |
| bus_rd_o | output | 1 | Read strobe |
| bus_wr_o | output | 1 | Write-commit strobe |
| bus_dat_i | input | DATA_W | Read value returned by the PHY |
| bus_ack_i | input | 1 | Handshake acknowledge from the PHY |

## Verification
The bench builds the block with TIMEOUT_CYC=40 and SETUP_CYC=3 instead of the defaults of 1000 and 2. The short watchdog lets stalled acknowledges be provoked in every handshake kind, and the acknowledge latency can be set on both sides of the exact limit (39 and 40 waiting cycles) within a short run. A settle period of three cycles shows that the settle length follows the parameter rather than a fixed count. The responding PHY model adds random rise and fall latencies, so a wide range of handshake timings is covered.

// File: rtl/creg_pkg.sv
package creg_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_SETUP,
      ST_ASSERT,
      ST_RELEASE
   } seq_state_t;

   typedef enum logic [1:0] {
      PH_ADDR,
      PH_DATA,
      PH_COMMIT,
      PH_READ
   } seq_phase_t;

   typedef struct packed {
      logic cap_addr;
      logic cap_data;
      logic rd;
      logic wr;
   } strobe_t;

endpackage

// File: rtl/creg_cycle_timer.sv
// Counts consecutive enabled cycles; hit marks the LIMIT-th one.
module creg_cycle_timer #(
   parameter int LIMIT = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic hit
);

   if (LIMIT < 1) begin : g_bad_limit
      $error("creg_cycle_timer: LIMIT must be at least 1");
   end

   if (LIMIT == 1) begin : g_single
      logic unused_tie;
      assign unused_tie = clk ^ rst_n;
      assign hit = en;
   end else begin : g_count
      localparam int CW = $clog2(LIMIT);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q <= '0;
         end else if (!en) begin
            cnt_q <= '0;
         end else if (cnt_q != CW'(LIMIT - 1)) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end

      assign hit = en && (cnt_q == CW'(LIMIT - 1));
   end

endmodule

// File: rtl/creg_strobe_decode.sv
// Maps sequencer state and phase onto the four bus strobes.
module creg_strobe_decode
   import creg_pkg::*;
(
   input  seq_state_t state,
   input  seq_phase_t phase,
   output strobe_t    stb
);

   logic active;
   assign active = (state == ST_ASSERT);

   always_comb begin
      stb = '0;
      if (active) begin
         unique case (phase)
            PH_ADDR:   stb.cap_addr = 1'b1;
            PH_DATA:   stb.cap_data = 1'b1;
            PH_COMMIT: stb.wr       = 1'b1;
            PH_READ:   stb.rd       = 1'b1;
            default:   stb          = '0;
         endcase
      end
   end

endmodule

// File: rtl/creg_seq_fsm.sv
// Handshake sequencer: walks address / data / commit or address / read.
module creg_seq_fsm
   import creg_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16,
   parameter int LANE_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_req,
   input  logic              host_we,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic              bus_ack,
   input  logic [DATA_W-1:0] bus_rdat,
   input  logic              setup_hit,
   input  logic              wait_hit,
   output seq_state_t        state,
   output seq_phase_t        phase,
   output logic [LANE_W-1:0] lane_dat,
   output logic [DATA_W-1:0] rdata,
   output logic              done,
   output logic              err,
   output logic              setup_en,
   output logic              wait_en
);

   seq_state_t        state_q;
   seq_phase_t        phase_q;
   logic              we_q;
   logic [DATA_W-1:0] wdata_q;
   logic [LANE_W-1:0] dat_q;
   logic [DATA_W-1:0] cap_q;
   logic [DATA_W-1:0] rdata_q;
   logic              done_q;
   logic              err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         phase_q <= PH_ADDR;
         we_q    <= 1'b0;
         wdata_q <= '0;
         dat_q   <= '0;
         cap_q   <= '0;
         rdata_q <= '0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (host_req) begin
                  we_q    <= host_we;
                  wdata_q <= host_wdata;
                  dat_q   <= LANE_W'(host_addr);
                  phase_q <= PH_ADDR;
                  state_q <= ST_SETUP;
               end
            end
            ST_SETUP: begin
               if (setup_hit) begin
                  state_q <= ST_ASSERT;
               end
            end
            ST_ASSERT: begin
               if (bus_ack) begin
                  if (phase_q == PH_READ) begin
                     cap_q <= bus_rdat;
                  end
                  state_q <= ST_RELEASE;
               end else if (wait_hit) begin
                  state_q <= ST_IDLE;
                  dat_q   <= '0;
                  done_q  <= 1'b1;
                  err_q   <= 1'b1;
               end
            end
            ST_RELEASE: begin
               if (!bus_ack) begin
                  unique case (phase_q)
                     PH_ADDR: begin
                        state_q <= ST_SETUP;
                        if (we_q) begin
                           phase_q <= PH_DATA;
                           dat_q   <= LANE_W'(wdata_q);
                        end else begin
                           phase_q <= PH_READ;
                           dat_q   <= '0;
                        end
                     end
                     PH_DATA: begin
                        phase_q <= PH_COMMIT;
                        state_q <= ST_SETUP;
                     end
                     PH_COMMIT: begin
                        state_q <= ST_IDLE;
                        dat_q   <= '0;
                        done_q  <= 1'b1;
                     end
                     PH_READ: begin
                        state_q <= ST_IDLE;
                        rdata_q <= cap_q;
                        done_q  <= 1'b1;
                     end
                     default: state_q <= ST_IDLE;
                  endcase
               end else if (wait_hit) begin
                  state_q <= ST_IDLE;
                  dat_q   <= '0;
                  done_q  <= 1'b1;
                  err_q   <= 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign state    = state_q;
   assign phase    = phase_q;
   assign lane_dat = dat_q;
   assign rdata    = rdata_q;
   assign done     = done_q;
   assign err      = err_q;
   assign setup_en = (state_q == ST_SETUP);
   assign wait_en  = ((state_q == ST_ASSERT) && !bus_ack) ||
                     ((state_q == ST_RELEASE) && bus_ack);

endmodule

// File: rtl/creg_bus_master.sv
// Top: host request port to strobe/acknowledge control bus.
module creg_bus_master
   import creg_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 16,
   parameter int SETUP_CYC   = 2,
   parameter int TIMEOUT_CYC = 1000,
   localparam int LANE_W     = (ADDR_W > DATA_W) ? ADDR_W : DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_req,
   input  logic              host_we,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic              host_done,
   output logic [DATA_W-1:0] host_rdata,
   output logic              host_err,
   output logic [LANE_W-1:0] bus_dat_o,
   output logic              bus_cap_addr_o,
   output logic              bus_cap_data_o,
   output logic              bus_rd_o,
   output logic              bus_wr_o,
   input  logic [DATA_W-1:0] bus_dat_i,
   input  logic              bus_ack_i
);

   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("creg_bus_master: widths must be positive");
   end
   if (SETUP_CYC < 1) begin : g_bad_setup
      $error("creg_bus_master: SETUP_CYC must be at least 1");
   end
   if (TIMEOUT_CYC < 2) begin : g_bad_timeout
      $error("creg_bus_master: TIMEOUT_CYC must be at least 2");
   end

   seq_state_t state;
   seq_phase_t phase;
   strobe_t    stb;
   logic       setup_en, setup_hit;
   logic       wait_en, wait_hit;

   creg_seq_fsm #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .LANE_W (LANE_W)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_req   (host_req),
      .host_we    (host_we),
      .host_addr  (host_addr),
      .host_wdata (host_wdata),
      .bus_ack    (bus_ack_i),
      .bus_rdat   (bus_dat_i),
      .setup_hit  (setup_hit),
      .wait_hit   (wait_hit),
      .state      (state),
      .phase      (phase),
      .lane_dat   (bus_dat_o),
      .rdata      (host_rdata),
      .done       (host_done),
      .err        (host_err),
      .setup_en   (setup_en),
      .wait_en    (wait_en)
   );

   creg_cycle_timer #(.LIMIT(SETUP_CYC)) u_settle (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (setup_en),
      .hit   (setup_hit)
   );

   creg_cycle_timer #(.LIMIT(TIMEOUT_CYC)) u_watchdog (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (wait_en),
      .hit   (wait_hit)
   );

   creg_strobe_decode u_decode (
      .state (state),
      .phase (phase),
      .stb   (stb)
   );

   assign bus_cap_addr_o = stb.cap_addr;
   assign bus_cap_data_o = stb.cap_data;
   assign bus_rd_o       = stb.rd;
   assign bus_wr_o       = stb.wr;

endmodule

// File: rtl/creg_bus_master_chk.sv
// Protocol checker, bound to every creg_bus_master instance.
module creg_bus_master_chk #(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 16,
   parameter int SETUP_CYC   = 2,
   parameter int TIMEOUT_CYC = 1000,
   parameter int LANE_W      = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_done,
   input logic [DATA_W-1:0] host_rdata,
   input logic              host_err,
   input logic [LANE_W-1:0] bus_dat_o,
   input logic              bus_cap_addr_o,
   input logic              bus_cap_data_o,
   input logic              bus_rd_o,
   input logic              bus_wr_o,
   input logic              bus_ack_i
);

   localparam int RW = $clog2(SETUP_CYC + 2);
   localparam int WW = $clog2(TIMEOUT_CYC + 2);

   logic              any_stb;
   logic [RW-1:0]     run_q;
   logic [LANE_W-1:0] prev_dat_q;
   logic [WW-1:0]     stall_q;

   assign any_stb = bus_cap_addr_o | bus_cap_data_o | bus_rd_o | bus_wr_o;

   // run_q: consecutive quiet cycles with an unchanged lane value, up to last cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q      <= '0;
         prev_dat_q <= '0;
         stall_q    <= '0;
      end else begin
         prev_dat_q <= bus_dat_o;
         if (any_stb) begin
            run_q <= '0;
         end else if (bus_dat_o == prev_dat_q && run_q != '0) begin
            if (run_q != RW'(SETUP_CYC + 1)) run_q <= run_q + 1'b1;
         end else begin
            run_q <= RW'(1);
         end
         if (any_stb && !bus_ack_i) begin
            if (stall_q != WW'(TIMEOUT_CYC + 1)) stall_q <= stall_q + 1'b1;
         end else begin
            stall_q <= '0;
         end
      end
   end

   p_settle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(any_stb) |-> (run_q >= RW'(SETUP_CYC)) && (bus_dat_o == prev_dat_q));

   p_lane_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (any_stb && $past(any_stb)) |-> $stable(bus_dat_o));

   p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({bus_cap_addr_o, bus_cap_data_o, bus_rd_o, bus_wr_o}));

   p_drop_after_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(any_stb) |-> ($past(bus_ack_i) || (host_done && host_err)));

   p_bounded_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (any_stb && !bus_ack_i) |-> (stall_q < WW'(TIMEOUT_CYC)));

   p_abort_keeps_rdata_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (host_done && host_err) |-> ($stable(host_rdata) && !any_stb));

   p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      host_done |=> !host_done);

   p_err_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      host_err |-> host_done);

endmodule

bind creg_bus_master creg_bus_master_chk #(
   .ADDR_W      (ADDR_W),
   .DATA_W      (DATA_W),
   .SETUP_CYC   (SETUP_CYC),
   .TIMEOUT_CYC (TIMEOUT_CYC),
   .LANE_W      (LANE_W)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .host_done      (host_done),
   .host_rdata     (host_rdata),
   .host_err       (host_err),
   .bus_dat_o      (bus_dat_o),
   .bus_cap_addr_o (bus_cap_addr_o),
   .bus_cap_data_o (bus_cap_data_o),
   .bus_rd_o       (bus_rd_o),
   .bus_wr_o       (bus_wr_o),
   .bus_ack_i      (bus_ack_i)
);

// File: tb/tb_creg_bus_master.sv
module tb_creg_bus_master;

   localparam int TO = 40;
   localparam int SU = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_req = 1'b0;
   logic        host_we = 1'b0;
   logic [15:0] host_addr = '0;
   logic [15:0] host_wdata = '0;
   logic        host_done;
   logic [15:0] host_rdata;
   logic        host_err;
   logic [15:0] bus_dat_o;
   logic        bus_cap_addr_o, bus_cap_data_o, bus_rd_o, bus_wr_o;
   logic [15:0] bus_dat_i = '0;
   logic        bus_ack_i = 1'b0;

   always #4 clk = ~clk;

   creg_bus_master #(
      .ADDR_W(16), .DATA_W(16), .SETUP_CYC(SU), .TIMEOUT_CYC(TO)
   ) dut (
      .clk(clk), .rst_n(rst_n),
      .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_done(host_done), .host_rdata(host_rdata),
      .host_err(host_err), .bus_dat_o(bus_dat_o),
      .bus_cap_addr_o(bus_cap_addr_o), .bus_cap_data_o(bus_cap_data_o),
      .bus_rd_o(bus_rd_o), .bus_wr_o(bus_wr_o),
      .bus_dat_i(bus_dat_i), .bus_ack_i(bus_ack_i)
   );

   int n_checks = 0;
   int n_fail   = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] def_val(input logic [15:0] a);
      return {a[7:0], a[15:8]} ^ 16'h5AC3;
   endfunction

   // ---------------- PHY responder model ----------------
   logic [15:0] phy_mem [logic [15:0]];
   logic [15:0] m_addr = '0, m_data = '0;
   logic [15:0] last_wr_addr = '0, last_wr_din = '0;
   int          n_commits = 0;
   int          stall_type = 0;   // 0 none, 1 ack never rises, 2 ack never falls
   int          stall_kind = -1;  // 0 addr, 1 data, 2 commit, 3 read
   int          rise_dly = 0, fall_dly = 0;
   int          rcnt = 0, fcnt = 0, cur_kind = -1;

   function automatic int kind_now();
      if (bus_cap_addr_o) return 0;
      if (bus_cap_data_o) return 1;
      if (bus_wr_o)       return 2;
      if (bus_rd_o)       return 3;
      return -1;
   endfunction

   always @(negedge clk) begin
      int k;
      k = kind_now();
      if (!rst_n) begin
         bus_ack_i = 1'b0; bus_dat_i = '0; rcnt = 0; fcnt = 0;
      end else if (!bus_ack_i) begin
         if (k >= 0 && !(stall_type == 1 && stall_kind == k)) begin
            if (rcnt >= rise_dly) begin
               bus_ack_i = 1'b1; rcnt = 0; cur_kind = k;
               case (k)
                  0: m_addr = bus_dat_o;
                  1: m_data = bus_dat_o;
                  2: begin
                     phy_mem[m_addr] = m_data;
                     last_wr_addr = m_addr; last_wr_din = bus_dat_o;
                     n_commits++;
                  end
                  default: bus_dat_i = phy_mem.exists(m_addr) ? phy_mem[m_addr] : def_val(m_addr);
               endcase
            end else rcnt++;
         end else rcnt = 0;
      end else begin
         if (k < 0 && !(stall_type == 2 && stall_kind == cur_kind)) begin
            if (fcnt >= fall_dly) begin
               bus_ack_i = 1'b0; bus_dat_i = '0; fcnt = 0;
            end else fcnt++;
         end else fcnt = 0;
      end
   end

   // ---------------- bus protocol monitor ----------------
   logic [15:0] mon_prev = '0;
   int mon_run = 0, hi_len = 0, last_hi_len = 0;
   bit prev_any = 1'b0;

   always @(negedge clk) begin
      bit any;
      any = bus_cap_addr_o | bus_cap_data_o | bus_rd_o | bus_wr_o;
      if (rst_n) begin
         if (any && !prev_any) begin
            chk(mon_run >= SU && bus_dat_o == mon_prev, "R5 settle before strobe", mon_run, SU);
            chk($countones({bus_cap_addr_o, bus_cap_data_o, bus_rd_o, bus_wr_o}) == 1,
                "R6 single strobe", {bus_cap_addr_o, bus_cap_data_o, bus_rd_o, bus_wr_o}, 0);
            if (bus_rd_o) chk(bus_dat_o == 16'h0, "R4 lane zero during read", bus_dat_o, 0);
         end
         if (any && !bus_ack_i) hi_len++;
         if (!any && prev_any) begin last_hi_len = hi_len; hi_len = 0; end
         if (any) mon_run = 0;
         else if (bus_dat_o == mon_prev && mon_run > 0) mon_run++;
         else mon_run = 1;
      end
      mon_prev = bus_dat_o;
      prev_any = any;
   end

   // ---------------- host side ----------------
   logic [15:0] exp_mem [logic [15:0]];
   logic [15:0] last_rdata = '0;

   function automatic logic [15:0] exp_read(input logic [15:0] a);
      return exp_mem.exists(a) ? exp_mem[a] : def_val(a);
   endfunction

   task automatic txn(input bit we, input logic [15:0] a, input logic [15:0] d,
                      output logic [15:0] r, output bit e);
      bit got;
      got = 1'b0; r = '0; e = 1'b0;
      @(negedge clk);
      host_req = 1'b1; host_we = we; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_req = 1'b0;
      for (int i = 0; i < 8 * TO + 100 && !got; i++) begin
         if (host_done) begin got = 1'b1; r = host_rdata; e = host_err; end
         else @(negedge clk);
      end
      chk(got, "R9 done pulse arrives", got, 1);
      @(negedge clk);
      chk(!host_done, "R9 done lasts one cycle", host_done, 0);
   endtask

   task automatic do_write(input logic [15:0] a, input logic [15:0] d);
      logic [15:0] r; bit e;
      txn(1'b1, a, d, r, e);
      chk(!e, "R3 write no error", e, 0);
      chk(last_wr_addr == a, "R3 commit address", last_wr_addr, a);
      chk(last_wr_din == d, "R3 data on lane at commit", last_wr_din, d);
      exp_mem[a] = d;
   endtask

   task automatic do_read(input logic [15:0] a);
      logic [15:0] r; bit e;
      txn(1'b0, a, 16'h0, r, e);
      chk(!e, "R4 read no error", e, 0);
      chk(r == exp_read(a), "R4 read value", r, exp_read(a));
      last_rdata = r;
   endtask

   task automatic settle_bus();
      stall_type = 0; stall_kind = -1; rise_dly = 0; fall_dly = 0;
      repeat (6) @(negedge clk);
   endtask

   initial begin
      repeat (TO * 3000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      logic [15:0] r; bit e; int commits0; int dones;
      void'($urandom(32'hC0DE5EED));
      repeat (4) @(negedge clk);
      chk({bus_cap_addr_o, bus_cap_data_o, bus_rd_o, bus_wr_o} == 4'b0, "R1 strobes low in reset",
          {bus_cap_addr_o, bus_cap_data_o, bus_rd_o, bus_wr_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(bus_dat_o == 16'h0 && !host_done && !host_err, "R1 quiet after reset",
          {bus_dat_o, 14'h0, host_done, host_err}, 0);

      // directed corners of the address space (R10)
      do_write(16'h0000, 16'h1234);
      do_write(16'hFFFF, 16'hBEEF);
      do_read(16'h0000);
      do_read(16'hFFFF);
      chk(last_rdata == 16'hBEEF, "R10 top address read back", last_rdata, 16'hBEEF);
      do_read(16'h8001);   // never written: default value (R4)

      // random mix with random acknowledge latencies (R2 R3 R4)
      for (int i = 0; i < 250; i++) begin
         logic [15:0] a;
         rise_dly = int'($urandom % 6);
         fall_dly = int'($urandom % 6);
         a = ($urandom % 3 == 0) ? 16'($urandom % 8) : 16'($urandom);
         if ($urandom % 2 == 1) do_write(a, 16'($urandom));
         else do_read(a);
      end
      settle_bus();

      // R7: acknowledge never rises on address capture; strobe held exactly TO cycles
      stall_type = 1; stall_kind = 0;
      txn(1'b0, 16'h0003, 16'h0, r, e);
      chk(e, "R7 abort on missing ack", e, 1);
      chk(r == last_rdata, "R7 rdata kept on abort", r, last_rdata);
      chk(last_hi_len == TO, "R7 strobe held for timeout", last_hi_len, TO);
      settle_bus();

      // R7: ack stuck high after data capture -> write never committed
      commits0 = n_commits;
      stall_type = 2; stall_kind = 1;
      txn(1'b1, 16'h0005, 16'hCAFE, r, e);
      chk(e, "R7 abort on ack stuck high", e, 1);
      settle_bus();
      chk(n_commits == commits0, "R7 no commit after abort", n_commits, commits0);
      do_read(16'h0005);

      // R7: read whose release stalls keeps old rdata
      stall_type = 2; stall_kind = 3;
      txn(1'b0, 16'h0000, 16'h0, r, e);
      chk(e && r == last_rdata, "R7 read abort keeps rdata", r, last_rdata);
      settle_bus();

      // R7 boundary: TO-1 waiting cycles completes, TO waiting cycles aborts
      rise_dly = TO - 1;
      txn(1'b1, 16'h0077, 16'h7777, r, e);
      chk(!e, "R7 ack within limit succeeds", e, 0);
      exp_mem[16'h0077] = 16'h7777;
      rise_dly = TO;
      txn(1'b0, 16'h0077, 16'h0, r, e);
      chk(e, "R7 ack one cycle late aborts", e, 1);
      settle_bus();
      do_read(16'h0077);

      // R8: requests while busy are ignored
      commits0 = n_commits; dones = 0;
      @(negedge clk);
      host_req = 1'b1; host_we = 1'b0; host_addr = 16'h0001;
      @(negedge clk);
      host_req = 1'b0;
      @(negedge clk);
      host_req = 1'b1; host_we = 1'b1; host_addr = 16'h0002; host_wdata = 16'hDEAD;
      repeat (2) @(negedge clk);
      host_req = 1'b0;
      for (int i = 0; i < 60; i++) begin
         if (host_done) begin
            dones++;
            chk(host_rdata == exp_read(16'h0001), "R8 first request served", host_rdata,
                exp_read(16'h0001));
            last_rdata = host_rdata;
         end
         @(negedge clk);
      end
      chk(dones == 1, "R8 single done for busy window", dones, 1);
      chk(n_commits == commits0, "R8 ignored write not committed", n_commits, commits0);
      do_read(16'h0002);

      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule